// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM controller from reset to its working configuration. It waits for a start pulse. It then captures the timing configuration word, the bank-group configuration word and an optional mode-operand override, and runs a fixed command program. The program is one NOP, then a long settling wait, then a burst of PRECHARGE, eight AUTO-REFRESH and one MODE-REGISTER-SET. Each command in the burst is spaced from the last by a guaranteed minimum number of cycles. The two waits are down-counters whose lengths are parameters in clock cycles. At 50 MHz the defaults give 200 us and 100 ns, which meet the 200 us and 80 ns minimums.

Every command leaves on a single-cycle strobe with a command word. The low two bits of the word are the command code. The bits above them carry the mode operand, which is ORed into every burst command. The block has no back-pressure: the controller must accept each strobe in the cycle it appears. The timing word handed to the controller has its refresh field forced to zero for the whole run. The complete word, with refresh, is released only after the mode-register command. A done flag follows one cycle later.

Top module: `sdram_init_seq`

## Requirements
- R1: During and after reset, `cmd_valid_o`, `refresh_en_o`, `done_o`, `mode_opnd_o` and `timing_o` are all zero.
- R2: The first strobe comes one cycle after the clock edge that samples `start_i`. It carries the NOP code 2'd0 with every other bit of `cmd_word_o` zero.
- R3: The PRECHARGE strobe follows the NOP strobe by exactly `PWR_CYC`+1 cycles.
- R4: The burst order is fixed: code 2'd1 (PRECHARGE), then eight strobes with code 2'd2 (AUTO-REFRESH), then one strobe with code 2'd3 (MODE-REGISTER-SET).
- R5: Successive burst strobes are exactly `GAP_CYC`+1 cycles apart, with `cmd_valid_o` low in between.
- R6: The computed operand depends on the CAS latency in timing bits [2:0] and on the width flag in group bit 9 (1 = 32-bit bus, 0 = 16-bit bus). The values are: 32-bit gives 0x40 for latency 2 and 0x60 otherwise; 16-bit gives 0x20 for latency 2 and 0x30 otherwise.
- R7: A nonzero override value replaces the computed operand unchanged.
- R8: Every burst strobe carries `cmd_word_o` = {operand, code}, and `mode_opnd_o` shows the operand in use.
- R9: `timing_o` is the captured timing word with bits [9:8] (the refresh field) cleared, and `refresh_en_o` is low, until the cycle after the MODE-REGISTER-SET strobe. From that cycle on, `refresh_en_o` is 1 and `timing_o` is the full captured word.
- R10: `done_o` rises one cycle after `refresh_en_o` and stays high until reset.
- R11: A start pulse has no effect while a sequence is running or after it has completed.
- R12: Each strobe lasts exactly one cycle.
- R13: Configuration inputs are captured on the accepted start, and later changes to them have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted only when idle after reset |
| timing_cfg_i | input | TW | Timing word: CAS latency in [2:0], refresh field in [9:8] |
| group_cfg_i | input | GW | Bank-group word: bus width flag in bit 9 |
| opnd_ovr_i | input | OP_W | Mode operand override, used when nonzero |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | OP_W+2 | Command word {operand, code} |
| mode_opnd_o | output | OP_W | Operand captured for this run |
| timing_o | output | TW | Timing word for the controller, refresh masked until the end |
| refresh_en_o | output | 1 | Refresh released |
| done_o | output | 1 | Initialization complete |

## Verification
The assertions check several properties on every cycle. Strobes never last more than one cycle. Burst commands are spaced exactly `GAP_CYC` idle cycles apart and carry the operand shown on `mode_opnd_o`. The refresh field stays zero while refresh is held off. Once refresh or done is set, it stays set. The MODE-REGISTER-SET strobe is followed directly by refresh release, and release is followed by done. Other behaviours can only be shown by the bench's scenarios: the exact program order, the length of the settling wait, the operand table across latency and width combinations, the override path, and the fact that start pulses and configuration changes in the middle of a run are ignored.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int CODE_W = 2;

  localparam logic [CODE_W-1:0] CODE_NOP  = 2'd0;
  localparam logic [CODE_W-1:0] CODE_PRE  = 2'd1;
  localparam logic [CODE_W-1:0] CODE_AREF = 2'd2;
  localparam logic [CODE_W-1:0] CODE_MODE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NOP,
    ST_SETTLE,
    ST_ISSUE,
    ST_SPACE,
    ST_RELEASE,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/sdram_init_opnd.sv
module sdram_init_opnd #(
  parameter int TW        = 32,
  parameter int GW        = 32,
  parameter int OP_W      = 8,
  parameter int WIDE_BIT  = 9
) (
  input  logic [TW-1:0]   timing_cfg_i,
  input  logic [GW-1:0]   group_cfg_i,
  input  logic [OP_W-1:0] opnd_ovr_i,
  output logic [OP_W-1:0] opnd_o
);

  logic [2:0]      cas_lat;
  logic            wide_bus;
  logic [OP_W-1:0] base_val;
  logic [OP_W-1:0] table_val;

  assign cas_lat  = timing_cfg_i[2:0];
  assign wide_bus = group_cfg_i[WIDE_BIT];

  always_comb begin
    base_val  = (cas_lat == 3'd2) ? OP_W'(8'h40) : OP_W'(8'h60);
    table_val = wide_bus ? base_val : (base_val >> 1);
    opnd_o    = (opnd_ovr_i != '0) ? opnd_ovr_i : table_val;
  end

endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_prog.sv
module sdram_init_prog
  import sdram_init_pkg::*;
#(
  parameter int NUM_AREF = 8,
  parameter int IW       = 4
) (
  input  logic [IW-1:0]     idx_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int NUM_CMD = NUM_AREF + 2;

  logic [CODE_W-1:0] prog [NUM_CMD];

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_step
    if (g == 0) begin : g_first
      assign prog[g] = CODE_PRE;
    end else if (g == NUM_CMD - 1) begin : g_last
      assign prog[g] = CODE_MODE;
    end else begin : g_mid
      assign prog[g] = CODE_AREF;
    end
  end

  always_comb begin
    code_o = CODE_NOP;
    for (int i = 0; i < NUM_CMD; i++) begin
      if (idx_i == IW'(i)) code_o = prog[i];
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int TW       = 32,
  parameter int GW       = 32,
  parameter int OP_W     = 8,
  parameter int WIDE_BIT = 9,
  parameter int REF_LSB  = 8,
  parameter int REF_W    = 2,
  parameter int NUM_AREF = 8,
  parameter int PWR_CYC  = 10000,
  parameter int GAP_CYC  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [TW-1:0]        timing_cfg_i,
  input  logic [GW-1:0]        group_cfg_i,
  input  logic [OP_W-1:0]      opnd_ovr_i,
  output logic                 cmd_valid_o,
  output logic [OP_W+1:0]      cmd_word_o,
  output logic [OP_W-1:0]      mode_opnd_o,
  output logic [TW-1:0]        timing_o,
  output logic                 refresh_en_o,
  output logic                 done_o
);

  localparam int NUM_CMD  = NUM_AREF + 2;
  localparam int IW       = $clog2(NUM_CMD);
  localparam int MAX_WAIT = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
  localparam int CW       = $clog2(MAX_WAIT + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_CMD - 1);
  localparam logic [TW-1:0] REF_MASK =
    {{(TW-REF_W){1'b0}}, {REF_W{1'b1}}} << REF_LSB;

  seq_state_e        state_q;
  logic [IW-1:0]     idx_q;
  logic [TW-1:0]     timing_q;
  logic [OP_W-1:0]   opnd_q;
  logic              ref_en_q;
  logic              done_q;

  logic [OP_W-1:0]   opnd_calc;
  logic [CODE_W-1:0] prog_code;
  logic              tmr_load;
  logic              tmr_dec;
  logic [CW-1:0]     tmr_val;
  logic              tmr_zero;

  sdram_init_opnd #(
    .TW       (TW),
    .GW       (GW),
    .OP_W     (OP_W),
    .WIDE_BIT (WIDE_BIT)
  ) u_opnd (
    .timing_cfg_i (timing_cfg_i),
    .group_cfg_i  (group_cfg_i),
    .opnd_ovr_i   (opnd_ovr_i),
    .opnd_o       (opnd_calc)
  );

  sdram_init_prog #(
    .NUM_AREF (NUM_AREF),
    .IW       (IW)
  ) u_prog (
    .idx_i  (idx_q),
    .code_o (prog_code)
  );

  sdram_init_timer #(
    .CW (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    tmr_load = (state_q == ST_NOP) ||
               (state_q == ST_ISSUE && idx_q != LAST_IDX);
    tmr_val  = (state_q == ST_NOP) ? CW'(PWR_CYC - 1) : CW'(GAP_CYC - 1);
    tmr_dec  = (state_q == ST_SETTLE) || (state_q == ST_SPACE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      timing_q <= '0;
      opnd_q   <= '0;
      ref_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            timing_q <= timing_cfg_i;
            opnd_q   <= opnd_calc;
            idx_q    <= '0;
            state_q  <= ST_NOP;
          end
        end
        ST_NOP:    state_q <= ST_SETTLE;
        ST_SETTLE: if (tmr_zero) state_q <= ST_ISSUE;
        ST_ISSUE: begin
          if (idx_q == LAST_IDX) begin
            ref_en_q <= 1'b1;
            state_q  <= ST_RELEASE;
          end else begin
            state_q  <= ST_SPACE;
          end
        end
        ST_SPACE: begin
          if (tmr_zero) begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_RELEASE: begin
          done_q  <= 1'b1;
          state_q <= ST_HOLD;
        end
        ST_HOLD:   state_q <= ST_HOLD;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = (state_q == ST_NOP) || (state_q == ST_ISSUE);
    if (state_q == ST_ISSUE) cmd_word_o = {opnd_q, prog_code};
    else                     cmd_word_o = '0;
  end

  assign mode_opnd_o  = opnd_q;
  assign timing_o     = ref_en_q ? timing_q : (timing_q & ~REF_MASK);
  assign refresh_en_o = ref_en_q;
  assign done_o       = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int TW      = 32,
  parameter int OP_W    = 8,
  parameter int REF_LSB = 8,
  parameter int REF_W   = 2,
  parameter int GAP_CYC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid_o,
  input logic [OP_W+1:0] cmd_word_o,
  input logic [OP_W-1:0] mode_opnd_o,
  input logic [TW-1:0]   timing_o,
  input logic            refresh_en_o,
  input logic            done_o
);

  logic [15:0] idle_run_q;
  logic [1:0]  code;
  logic        burst_follow;

  assign code         = cmd_word_o[1:0];
  assign burst_follow = cmd_valid_o && (code == 2'd2 || code == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n)                  idle_run_q <= '0;
    else if (cmd_valid_o)        idle_run_q <= '0;
    else if (idle_run_q != '1)   idle_run_q <= idle_run_q + 1'b1;
  end

  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  assert_burst_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_follow |-> idle_run_q == 16'(GAP_CYC));

  assert_operand_merged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && code != 2'd0) |-> cmd_word_o[OP_W+1:2] == mode_opnd_o);

  assert_refresh_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en_o |-> timing_o[REF_LSB +: REF_W] == '0);

  assert_refresh_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en_o |=> refresh_en_o);

  assert_refresh_after_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && code == 2'd3) |=> $rose(refresh_en_o));

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refresh_en_o) |=> $rose(done_o));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_quiet_when_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cmd_valid_o);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .TW      (TW),
  .OP_W    (OP_W),
  .REF_LSB (REF_LSB),
  .REF_W   (REF_W),
  .GAP_CYC (GAP_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_word_o   (cmd_word_o),
  .mode_opnd_o  (mode_opnd_o),
  .timing_o     (timing_o),
  .refresh_en_o (refresh_en_o),
  .done_o       (done_o)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int P  = 20;
  localparam int G  = 3;
  localparam int F  = P + 2;
  localparam int LAST_N = F + 9 * (G + 1);
  localparam logic [31:0] RMASK = 32'h0000_0300;

  typedef struct packed {
    logic [31:0] tim;
    logic [31:0] grp;
    logic [7:0]  ovr;
    logic [7:0]  op;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0302, 32'h0000_0200, 8'h00, 8'h40},
    '{32'h0000_0103, 32'h0000_0201, 8'h00, 8'h60},
    '{32'h0000_0202, 32'h0000_0000, 8'h00, 8'h20},
    '{32'h0000_0303, 32'hFFFF_FDFF, 8'h00, 8'h30},
    '{32'h0000_0105, 32'h0000_0200, 8'h00, 8'h60},
    '{32'h0000_0302, 32'h0000_0200, 8'h5A, 8'h5A},
    '{32'h0000_0202, 32'h0000_0000, 8'h01, 8'h01},
    '{32'hABCD_EF0A, 32'h0000_0600, 8'h00, 8'h40}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] timing_cfg_i = '0;
  logic [31:0] group_cfg_i = '0;
  logic [7:0]  opnd_ovr_i = '0;
  logic        cmd_valid_o;
  logic [9:0]  cmd_word_o;
  logic [7:0]  mode_opnd_o;
  logic [31:0] timing_o;
  logic        refresh_en_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .PWR_CYC (P),
    .GAP_CYC (G)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .timing_cfg_i (timing_cfg_i),
    .group_cfg_i  (group_cfg_i),
    .opnd_ovr_i   (opnd_ovr_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_word_o   (cmd_word_o),
    .mode_opnd_o  (mode_opnd_o),
    .timing_o     (timing_o),
    .refresh_en_o (refresh_en_o),
    .done_o       (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle_outputs(input string req);
    chk(cmd_valid_o == 1'b0,  req, 32'(cmd_valid_o), 0);
    chk(refresh_en_o == 1'b0, req, 32'(refresh_en_o), 0);
    chk(done_o == 1'b0,       req, 32'(done_o), 0);
    chk(timing_o == '0,       req, timing_o, 0);
    chk(mode_opnd_o == '0,    req, 32'(mode_opnd_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1");
    rst_n = 1'b1;
  endtask

  // Expected command schedule, n counted in edges from the start edge (n=1).
  function automatic bit exp_valid(input int n);
    if (n == 1) return 1'b1;
    if (n < F || n > LAST_N) return 1'b0;
    return ((n - F) % (G + 1)) == 0;
  endfunction

  function automatic logic [1:0] exp_code(input int n);
    int k;
    if (n == 1) return 2'd0;
    k = (n - F) / (G + 1);
    if (k == 0) return 2'd1;
    if (k == 9) return 2'd3;
    return 2'd2;
  endfunction

  task automatic run_vector(input vec_t v);
    logic [9:0]  ew;
    logic [31:0] et;
    do_reset();
    timing_cfg_i = v.tim;
    group_cfg_i  = v.grp;
    opnd_ovr_i   = v.ovr;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
    for (int n = 1; n <= LAST_N + 4; n++) begin
      if (n > 1) @(negedge clk);
      ew = (n == 1) ? 10'h000 : {v.op, exp_code(n)};
      chk(cmd_valid_o == exp_valid(n), "R2 R3 R4 R5 R12 strobe schedule",
          32'(cmd_valid_o), 32'(exp_valid(n)));
      if (exp_valid(n))
        chk(cmd_word_o == ew, "R2 R4 R6 R7 R8 command word",
            32'(cmd_word_o), 32'(ew));
      chk(mode_opnd_o == v.op, "R6 R7 operand", 32'(mode_opnd_o), 32'(v.op));
      et = (n >= LAST_N + 1) ? v.tim : (v.tim & ~RMASK);
      chk(timing_o == et, "R9 timing word", timing_o, et);
      chk(refresh_en_o == (n >= LAST_N + 1), "R9 refresh enable",
          32'(refresh_en_o), 32'(n >= LAST_N + 1));
      chk(done_o == (n >= LAST_N + 2), "R10 done", 32'(done_o),
          32'(n >= LAST_N + 2));
      // R11 and R13: second start and config change mid-run
      if (n == 10) begin
        start_i = 1'b1;
        timing_cfg_i = ~v.tim;
        group_cfg_i  = ~v.grp;
        opnd_ovr_i   = 8'hC3;
      end else if (n == 11) begin
        start_i = 1'b0;
      end else if (n == F + 2) begin
        start_i = 1'b1;
      end else if (n == F + 3) begin
        start_i = 1'b0;
      end
    end
    // R11: start after completion is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 30; k++) begin
      chk(cmd_valid_o == 1'b0, "R11 no strobe after done", 32'(cmd_valid_o), 0);
      chk(done_o == 1'b1, "R10 done held", 32'(done_o), 1);
      chk(timing_o == v.tim, "R13 timing unchanged", timing_o, v.tim);
      @(negedge clk);
    end
  endtask

  initial begin
    // Reset state
    do_reset();
    // Vector table walk
    for (int i = 0; i < 8; i++) run_vector(VECS[i]);
    // R10: done clears only through reset
    do_reset();
    // Directed: reset in the middle of the settling wait aborts the run
    timing_cfg_i = 32'h0000_0302;
    group_cfg_i  = 32'h0000_0200;
    opnd_ovr_i   = 8'h00;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 mid-run reset");
    rst_n = 1'b1;
    // Directed: without a start nothing is issued
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(cmd_valid_o == 1'b0, "R2 idle without start", 32'(cmd_valid_o), 0);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule